// File: doc/BRIEF.md
# Configurable Two/Three-Wire Serial Shifter

This block moves 4 or 8 bits at a time between a parallel register and a serial line. In three-wire mode it drives a push-pull data output and reads a separate data input. In two-wire mode it shares one open-drain data line, so the received byte is the wired-AND of its own bits and the far end's bits. Open-drain pins are modelled as output enables that pull the line low.

A CPU writes a configuration byte, loads the transmit data and writes a start bit. Configuration covers transfer length, bit order, an internal clock at one of four rates or an external clock, the active clock edge, two-wire mode and interrupt enable. The internal clock comes from a tick divider of the system clock. The external clock passes through a two-flop synchroniser before edge detection. Each bit samples the input on the active edge and launches the next output bit on the opposite edge. The clock rests at its inactive level between transfers. The same register holds the transmit data and, once the transfer ends, the received data.

Top module: `sio_shifter`

## Requirements
- R1: After reset busy_o, irq_o and sda_oe_o are 0, sck_o is 0, sck_oe_o is 1 and the configuration register reads 0.
- R2: The register at address 0 holds data: a write loads the transmit byte and a read returns the received byte. Address 1 holds the configuration byte. At address 2, a write with bit 0 set starts a transfer and a write with bit 1 set clears the interrupt. Reading address 2 returns irq in bit 1 and busy in bit 0.
- R3: Configuration bit 0 selects 8 bits (1) or 4 bits (0). A 4-bit transfer uses bits 3:0 and leaves bits 7:4 of the received byte reading 0. A transfer spans exactly 2×length clock edges.
- R4: Configuration bit 1 selects LSB first (1) or MSB first (0) for both transmit and receive.
- R5: Configuration bits 3:2 select the internal half-period as BASE_HALF system cycles times 1, 2, 3 or 6 for codes 0 to 3. The first clock edge comes one half-period after the start write takes effect.
- R6: Configuration bit 5 selects the falling edge (1) or the rising edge (0) as active. The clock rests at the level of bit 5. Input is sampled on the active edge and output changes on the other edge.
- R7: With configuration bit 4 set, the clock comes from ext_sck_i through a two-flop synchroniser and sck_oe_o stays 0. An inactive edge that arrives before the first active edge is ignored.
- R8: With configuration bit 6 set, data uses the open-drain line. sda_oe_o is 1 only while busy and the outgoing bit is 0, input is read from sda_i, sdo_o stays 0, and the internal clock is driven (sck_oe_o=1) only while it is low.
- R9: busy_o rises on the cycle after the start write and falls on the last edge. A start request while busy is ignored.
- R10: Data and configuration writes while busy are ignored.
- R11: With configuration bit 7 set, irq_o rises on the same clock as busy_o falls and stays high until cleared. With bit 7 clear, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Completion interrupt |
| sdo_o | output | 1 | Three-wire serial data out |
| sdi_i | input | 1 | Three-wire serial data in |
| sda_i | input | 1 | Open-drain data line sensed |
| sda_oe_o | output | 1 | Pull data line low |
| sck_o | output | 1 | Serial clock level |
| sck_oe_o | output | 1 | Serial clock drive enable |
| ext_sck_i | input | 1 | External serial clock |

## Verification
Assertions check on every cycle that the clock is back at its resting level when busy drops and that exactly 2×length edges were taken. They also check that the configuration cannot change mid-transfer, that the interrupt rises only together with the end of a transfer, and that the open-drain data line is pulled only during a transfer. Only the bench scenarios can show the bit order, the half-period timing for each rate code, the wired-AND receive in two-wire mode, and the rejection of an early inactive external edge. They do this by comparing the waveform against a timing model every cycle and the received byte at the end.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned XFER_W = 8;

  typedef struct packed {
    logic       irq_en;
    logic       two_wire;
    logic       fall_act;
    logic       ext_clk;
    logic [1:0] rate;
    logic       lsb_first;
    logic       len8;
  } sio_cfg_t;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  function automatic int unsigned rate_mult(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 3;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen
  import sio_pkg::*;
#(
  parameter int unsigned BASE_HALF = 56
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  localparam int unsigned MAX_HALF = BASE_HALF * 6;
  localparam int unsigned CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb lim = CW'(BASE_HALF * rate_mult(rate_i) - 1);

  // counter held at zero while idle so every transfer starts on a full half-period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == lim) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == lim);
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sck_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         load_i,
  input  logic [W-1:0] wdata_i,
  input  logic         len8_i,
  input  logic         lsb_i,
  input  logic         fall_act_i,
  input  logic         act_ev_i,
  input  logic         inact_ev_i,
  input  logic         sin_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         sout_o,
  output logic         sck_o,
  output logic [W-1:0] rdata_o
);
  localparam int unsigned HALF = W / 2;
  localparam int unsigned ECW  = $clog2(2 * W);

  logic [W-1:0]   sr_q, sr_nxt;
  logic [ECW-1:0] edge_q, last_idx;
  logic           busy_q, in_q, sck_q;
  logic           take_act, take_inact;

  assign last_idx   = len8_i ? ECW'(2 * W - 1) : ECW'(W - 1);
  // even edge index expects the active edge, odd expects the inactive one
  assign take_act   = busy_q & ~edge_q[0] & act_ev_i;
  assign take_inact = busy_q &  edge_q[0] & inact_ev_i;
  assign done_o     = take_inact && (edge_q == last_idx);

  always_comb begin
    if (!lsb_i)      sr_nxt = {sr_q[W-2:0], in_q};
    else if (len8_i) sr_nxt = {in_q, sr_q[W-1:1]};
    else             sr_nxt = {sr_q[W-1:HALF], in_q, sr_q[HALF-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sr_q   <= '0;
      edge_q <= '0;
      in_q   <= 1'b0;
      sck_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        sck_q  <= fall_act_i;
      end else if (load_i) begin
        sr_q <= wdata_i;
      end
    end else if (take_act) begin
      in_q   <= sin_i;
      edge_q <= edge_q + 1'b1;
      sck_q  <= ~sck_q;
    end else if (take_inact) begin
      sr_q   <= sr_nxt;
      sck_q  <= ~sck_q;
      edge_q <= done_o ? '0 : edge_q + 1'b1;
      if (done_o) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign sout_o  = lsb_i ? sr_q[0] : (len8_i ? sr_q[W-1] : sr_q[HALF-1]);
  assign sck_o   = busy_q ? sck_q : fall_act_i;
  assign rdata_o = len8_i ? sr_q : {{(W-HALF){1'b0}}, sr_q[HALF-1:0]};

  AST_SCK_IDLE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_q) |-> (sck_q == fall_act_i)) else $error("clock not at rest level after transfer"); // R6
  AST_EDGE_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_q) |-> ($past(edge_q) == last_idx)) else $error("wrong edge count at end of transfer"); // R3
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int unsigned BASE_HALF = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [XFER_W-1:0] wdata_i,
  output logic [XFER_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              ext_sck_i
);
  sio_cfg_t          cfg_q;
  logic              irq_q;
  logic              busy, done, sout, core_sck;
  logic              wr_cfg, wr_data, start_req, irq_clr;
  logic              tick, ext_rise, ext_fall, act_ev, inact_ev, sin;
  logic [XFER_W-1:0] core_rdata;

  assign wr_cfg    = wr_en_i && addr_i == A_CFG  && !busy;
  assign wr_data   = wr_en_i && addr_i == A_DATA && !busy;
  assign start_req = wr_en_i && addr_i == A_CTRL && wdata_i[0];
  assign irq_clr   = wr_en_i && addr_i == A_CTRL && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (wr_cfg) cfg_q <= sio_cfg_t'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_q <= 1'b0;
    else if (done && cfg_q.irq_en) irq_q <= 1'b1;
    else if (irq_clr)              irq_q <= 1'b0;
  end

  sio_tick_gen #(.BASE_HALF(BASE_HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy & ~cfg_q.ext_clk),
    .rate_i (cfg_q.rate),
    .tick_o (tick)
  );

  sio_edge_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (ext_sck_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  always_comb begin
    if (cfg_q.ext_clk) begin
      act_ev   = cfg_q.fall_act ? ext_fall : ext_rise;
      inact_ev = cfg_q.fall_act ? ext_rise : ext_fall;
    end else begin
      act_ev   = tick;
      inact_ev = tick;
    end
  end

  assign sin = cfg_q.two_wire ? sda_i : sdi_i;

  sio_shift_core #(.W(XFER_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_req),
    .load_i     (wr_data),
    .wdata_i    (wdata_i),
    .len8_i     (cfg_q.len8),
    .lsb_i      (cfg_q.lsb_first),
    .fall_act_i (cfg_q.fall_act),
    .act_ev_i   (act_ev),
    .inact_ev_i (inact_ev),
    .sin_i      (sin),
    .busy_o     (busy),
    .done_o     (done),
    .sout_o     (sout),
    .sck_o      (core_sck),
    .rdata_o    (core_rdata)
  );

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = core_rdata;
      A_CFG:   rdata_o = cfg_q;
      A_CTRL:  rdata_o = {{(XFER_W-2){1'b0}}, irq_q, busy};
      default: rdata_o = '0;
    endcase
  end

  assign busy_o   = busy;
  assign irq_o    = irq_q;
  assign sdo_o    = ~cfg_q.two_wire & sout;
  assign sda_oe_o = cfg_q.two_wire & busy & ~sout;
  assign sck_o    = cfg_q.ext_clk ? cfg_q.fall_act : core_sck;
  assign sck_oe_o = ~cfg_q.ext_clk & (cfg_q.two_wire ? ~core_sck : 1'b1);

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy && $past(busy)) |-> $stable(cfg_q)) else $error("config changed during transfer"); // R10
  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(irq_q) |-> $fell(busy)) else $error("interrupt without completion"); // R11
  AST_OD_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) sda_oe_o |-> busy) else $error("data line pulled while idle"); // R8
  AST_START_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(busy) |-> ($past(start_req) && !$past(busy))) else $error("busy rose without idle start"); // R9
endmodule

// File: tb/sio_shifter_tb.sv
module sio_shifter_tb;
  localparam int BH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       busy, irq, sdo, sda_oe, sck, sck_oe;
  logic       sdi = 1'b0;
  logic       slave_sda = 1'b1;
  logic       ext_sck = 1'b0;
  wire        sda_line = ~sda_oe & slave_sda;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sio_shifter #(.BASE_HALF(BH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy), .irq_o(irq), .sdo_o(sdo), .sdi_i(sdi),
    .sda_i(sda_line), .sda_oe_o(sda_oe), .sck_o(sck), .sck_oe_o(sck_oe),
    .ext_sck_i(ext_sck)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic int mult(input logic [1:0] r);
    case (r) 2'd0: return 1; 2'd1: return 2; 2'd2: return 3; default: return 6; endcase
  endfunction

  function automatic logic bit_at(input logic [7:0] v, input int len, input bit lsb, input int j);
    return lsb ? v[j] : v[len-1-j];
  endfunction

  task automatic run_xfer(input logic [7:0] cfg, input logic [7:0] tx, input logic [7:0] rv,
                          input bit disturb, input string tag);
    int len, h, s, n, e, j, mism, limit;
    bit lsb, idle, tw, eb, xb, e_sck, e_oe;
    logic [7:0] mask, v, exp_rx;
    string first;
    len = cfg[0] ? 8 : 4; lsb = cfg[1]; idle = cfg[5]; tw = cfg[6];
    h = BH * mult(cfg[3:2]); mask = cfg[0] ? 8'hFF : 8'h0F;
    wr(2'd1, cfg);
    wr(2'd0, tx);
    sdi = bit_at(rv, len, lsb, 0); slave_sda = sdi;
    wr(2'd2, 8'h01);
    s = cyc; mism = 0; first = ""; limit = 2 * len * h + 3;
    while (cyc - s <= limit) begin
      n = cyc - s;
      e = n / h; if (e > 2 * len) e = 2 * len;
      eb = (e < 2 * len);
      j = e / 2; if (j > len - 1) j = len - 1;
      xb = bit_at(tx, len, lsb, j);
      e_sck = eb ? (idle ^ (e % 2 == 1)) : idle;
      e_oe = tw ? ~e_sck : 1'b1;
      if (busy !== eb || sck !== e_sck || sck_oe !== e_oe || sda_oe !== (tw & eb & ~xb) ||
          (eb && sdo !== (tw ? 1'b0 : xb))) begin
        if (mism == 0)
          first = $sformatf("n=%0d busy=%b/%b sck=%b/%b oe=%b/%b sda_oe=%b sdo=%b bit=%b",
                            n, busy, eb, sck, e_sck, sck_oe, e_oe, sda_oe, sdo, xb);
        mism++;
      end
      sdi = bit_at(rv, len, lsb, j); slave_sda = sdi;
      if (disturb) begin
        if (n == 2) begin wr_en = 1'b1; addr = 2'd2; wdata = 8'h01; end
        if (n == 3) begin addr = 2'd0; wdata = ~tx; end
        if (n == 4) begin addr = 2'd1; wdata = ~cfg; end
        if (n == 5) wr_en = 1'b0;
      end
      @(negedge clk);
    end
    if (mism != 0) $display("  %s first waveform mismatch %s", tag, first);
    chk({tag, " waveform/timing"}, mism, 0);
    exp_rx = (tw ? (rv & tx) : rv) & mask;
    rd(2'd0, v);
    chk({tag, " received data"}, v, exp_rx);
    rd(2'd2, v);
    chk({tag, " irq status"}, v, {6'd0, cfg[7], 1'b0});
    if (disturb) begin
      rd(2'd1, v);
      chk({tag, " R10 config unchanged"}, v, cfg);
    end
    if (cfg[7]) begin
      wr(2'd2, 8'h02);
      chk({tag, " R11 irq cleared"}, irq, 0);
    end
  endtask

  task automatic wait_n(input int k, inout int bad);
    repeat (k) begin
      @(negedge clk);
      if (sck_oe !== 1'b0) bad++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck", sck, 0);
    chk("R1 sck_oe", sck_oe, 1);
    chk("R1 sda_oe", sda_oe, 0);
    rd(2'd1, v);
    chk("R1 config", v, 0);

    run_xfer(8'b1000_0001, 8'hA5, 8'h3C, 1'b0, "R2 R3 R4 R5 R6 R9 R11 msb8 rate0");
    run_xfer(8'b0010_0111, 8'h96, 8'hC1, 1'b0, "R4 R6 R11 lsb8 falling rate1");
    run_xfer(8'b1000_1000, 8'hFB, 8'h06, 1'b0, "R3 R5 msb4 rate2");
    run_xfer(8'b0000_1110, 8'h0D, 8'hF9, 1'b0, "R3 R4 R5 lsb4 rate3");
    run_xfer(8'b1100_0001, 8'hFF, 8'h5A, 1'b0, "R8 open-drain msb8");
    run_xfer(8'b0110_0011, 8'hF0, 8'h3C, 1'b0, "R8 open-drain lsb8 falling");
    run_xfer(8'b1000_0101, 8'h5C, 8'hE3, 1'b1, "R9 R10 writes while busy");

    // external clock, rising active, msb8; early inactive edge must be ignored (R7)
    bad = 0;
    wr(2'd1, 8'b1001_0001);
    wr(2'd0, 8'h3C);
    ext_sck = 1'b1;
    wait_n(5, bad);
    sdi = 1'b1;
    wr(2'd2, 8'h01);
    ext_sck = 1'b0;
    wait_n(6, bad);
    for (int j = 0; j < 8; j++) begin
      sdi = v_bit(8'hA7, j);
      wait_n(6, bad);
      ext_sck = 1'b1;
      wait_n(6, bad);
      if (j == 7) chk("R7 busy before last edge", busy, 1);
      ext_sck = 1'b0;
      wait_n(6, bad);
    end
    chk("R7 clock never driven", bad, 0);
    chk("R7 busy after last edge", busy, 0);
    rd(2'd0, v);
    chk("R7 external received data", v, 8'hA7);
    chk("R7 R11 irq after external transfer", irq, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic v_bit(input logic [7:0] v, input int j);
    return v[7-j];
  endfunction
endmodule